// File: doc/BRIEF.md
# Reorder Buffer with Serial Rollback

This block is the in-order bookkeeping queue of an out-of-order core that keeps all results in a single physical register file. It stores no data values. Each slot holds only control state: an instruction identifier, whether the instruction writes a register, the architectural destination, the physical tag the instruction was given (new tag), and the tag that destination mapped to before (previous tag). The dispatch stage writes an entry at the tail, the execution units mark entries finished by slot index, and the oldest entry leaves from the head once it has finished. When an entry leaves, its previous tag is the register that can be recycled, so the block reports that tag to the free list.

To restore precise state, a recovery request names the youngest slot to keep. The block then walks backward from the tail, one slot per cycle, and emits an undo command for each discarded instruction. The command names the instruction so its scheduler slot can be released. For instructions with a destination it also tells the rename stage to hand the new tag back to the free list and to write the previous tag back into the map. Dispatch and retirement are held off until the walk ends.

Top module: `rollback_rob`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_idx` is 0, and `ret_valid`, `undo_valid` and `rb_busy` are 0.
- R2: An accepted dispatch takes the slot shown on `disp_idx` in that cycle. Slots are handed out in increasing order, modulo DEPTH.
- R3: When DEPTH entries are held, `disp_ready` is 0 and a dispatch request is dropped: no entry is created for it. `disp_ready` returns to 1 after a retirement. There is no same-cycle bypass.
- R4: Retirement is strictly oldest first. The head retires, with `ret_valid` high for one cycle, only in the cycle after it has been marked complete. Completing a younger slot never retires it ahead of an unfinished head.
- R5: A retirement presents the entry's identifier and `ret_has_dst`. When `ret_has_dst` is 1, `ret_told` is the previous tag to be returned to the free list. When it is 0, nothing is to be freed.
- R6: A recovery request (`flush_valid`, `flush_idx` = youngest slot kept) raises `rb_busy` in the next cycle. From that cycle on, one entry per cycle is undone, youngest first. Each undo shows the entry's identifier, `undo_has_dst`, destination, new tag and previous tag.
- R7: The walk stops once the slot just after `flush_idx` is the next free slot. `rb_busy` stays high for one more cycle with no undo, so a walk of k entries keeps `rb_busy` high for k+1 cycles. The kept entries later retire normally, and the next dispatch reuses the first undone slot.
- R8: While `rb_busy` is 1, `disp_ready` and `ret_valid` are 0, and any further recovery request is ignored.
- R9: A dispatch accepted in the same cycle as a recovery request belongs to the discarded range and is the first entry undone.
- R10: A recovery request naming the youngest held slot undoes nothing and keeps `rb_busy` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_id | input | ID_W | Instruction identifier |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_areg | input | AREG_W | Architectural destination |
| disp_tag | input | TAG_W | New physical tag |
| disp_told | input | TAG_W | Physical tag previously mapped to the destination |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | log2(DEPTH) | Slot taken by a dispatch this cycle |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_idx | input | log2(DEPTH) | Slot that completed |
| flush_valid | input | 1 | Recovery request |
| flush_idx | input | log2(DEPTH) | Youngest slot to keep |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_id | output | ID_W | Identifier of the retiring entry |
| ret_has_dst | output | 1 | Retiring entry frees a register |
| ret_told | output | TAG_W | Previous tag returned to the free list |
| undo_valid | output | 1 | An entry is undone this cycle |
| undo_id | output | ID_W | Identifier of the undone entry (release its scheduler slot) |
| undo_has_dst | output | 1 | Undone entry has a destination to restore |
| undo_areg | output | AREG_W | Map entry to restore |
| undo_tag | output | TAG_W | New tag returned to the free list |
| undo_told | output | TAG_W | Previous tag written back to the map |
| rb_busy | output | 1 | Rollback walk in progress |

## Verification
Two collisions matter. The first is a dispatch in the very cycle a recovery request arrives. The bench drives both together and expects the just-dispatched instruction to be the first undo, followed by its elder. The second is a completion of the head landing in the cycle that starts a walk, while a second recovery request and another dispatch are also attempted during the walk. Here the bench expects no retirement and no acceptance until `rb_busy` falls. It then expects the head to retire in the following cycle and the walk length to be unchanged by the ignored request. A scoreboard queue mirrors the buffer: retirements are popped from its front and undos from its back, and every field is compared.

// File: rtl/rob_pkg.sv
// Shared widths and types for the rollback reorder buffer.
// Assumes all users agree on these widths; the depth is a module parameter.
package rob_pkg;
    parameter int ID_W   = 8;
    parameter int AREG_W = 5;
    parameter int TAG_W  = 7;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              has_dst;
        logic [AREG_W-1:0] areg;
        logic [TAG_W-1:0]  tag;
        logic [TAG_W-1:0]  told;
    } rob_entry_t;

    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_WALK = 1'b1
    } rb_state_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointer control for the reorder buffer.
// Pointers carry one wrap bit above the index so full and empty differ.
// Owns the rollback walk: the tail steps back one slot per cycle until
// it reaches the slot after the kept boundary.
// Assumes DEPTH is a power of two and flush_idx names a held slot.
module rob_ptrs
    import rob_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             head_done,
    input  logic             flush_req,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] tail_ptr,
    output logic             disp_fire,
    output logic             ret_fire,
    output logic             undo_fire,
    output logic             rb_busy,
    output logic             disp_ready
);
    rb_state_e        state;
    logic [IDX_W-1:0] keep_idx;
    logic [IDX_W-1:0] stop_idx;
    logic             empty;
    logic             full;
    logic [PTR_W:0]   walk_cnt;

    // Occupancy decode from the wrap-extended pointers.
    always_comb begin
        empty = (head_ptr == tail_ptr);
        full  = (head_ptr[IDX_W-1:0] == tail_ptr[IDX_W-1:0]) &&
                (head_ptr[IDX_W] != tail_ptr[IDX_W]);
    end

    // Handshake decisions for this cycle.
    always_comb begin
        stop_idx   = keep_idx + IDX_W'(1);
        rb_busy    = (state == RB_WALK);
        disp_ready = !full && !rb_busy;
        disp_fire  = disp_req && disp_ready;
        ret_fire   = !empty && head_done && !rb_busy;
        undo_fire  = rb_busy && (tail_ptr[IDX_W-1:0] != stop_idx);
    end

    // Rollback state: enter on request, leave when the boundary is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RB_IDLE;
            keep_idx <= '0;
        end else if (state == RB_IDLE) begin
            if (flush_req) begin
                state    <= RB_WALK;
                keep_idx <= flush_idx;
            end
        end else if (!undo_fire) begin
            state <= RB_IDLE;
        end
    end

    // Tail moves forward on dispatch, backward on undo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_ptr <= '0;
        end else if (disp_fire) begin
            tail_ptr <= tail_ptr + PTR_W'(1);
        end else if (undo_fire) begin
            tail_ptr <= tail_ptr - PTR_W'(1);
        end
    end

    // Head moves forward on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
        end else if (ret_fire) begin
            head_ptr <= head_ptr + PTR_W'(1);
        end
    end

    // Length of the current walk, for the termination check.
    always_ff @(posedge clk) begin
        if (!rst_n || !rb_busy) begin
            walk_cnt <= '0;
        end else begin
            walk_cnt <= walk_cnt + 1'b1;
        end
    end

    // Occupancy never exceeds the depth.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(tail_ptr - head_ptr) <= PTR_W'(DEPTH)));

    // Each undo removes exactly one slot from the tail.
    assert_undo_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undo_fire |=> (tail_ptr == $past(tail_ptr) - PTR_W'(1)));

    // An undo never happens on an empty buffer.
    assert_undo_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undo_fire |-> !empty);

    // A walk lasts at most DEPTH undo cycles plus the closing cycle.
    assert_walk_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_cnt <= (PTR_W+1)'(DEPTH));

    // The head is frozen during a walk.
    assert_head_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_busy && $past(rb_busy)) |-> $stable(head_ptr));
endmodule

// File: rtl/rob_store.sv
// Entry storage for the reorder buffer: payload array plus one
// completion flag per slot. Reads the head slot and the youngest slot.
// Assumes a slot is never completed in the cycle it is allocated.
module rob_store
    import rob_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  rob_entry_t        wr_entry,
    input  logic              cmpl_en,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [ID_W-1:0]   head_id,
    output logic              head_has_dst,
    output logic [TAG_W-1:0]  head_told,
    output logic              head_done,
    output rob_entry_t        last_entry
);
    rob_entry_t       slots [DEPTH];
    logic [DEPTH-1:0] done;

    // Payload write; payload needs no reset since done/pointers guard it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_entry;
        end
    end

    // Per-slot completion flag: cleared on allocation, set on completion.
    for (genvar g = 0; g < DEPTH; g++) begin : g_done
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                done[g] <= 1'b0;
            end else if (cmpl_en && (cmpl_idx == IDX_W'(g))) begin
                done[g] <= 1'b1;
            end
        end
    end

    // Read ports for retirement and for the rollback walk.
    always_comb begin
        head_id      = slots[head_idx].id;
        head_has_dst = slots[head_idx].has_dst;
        head_told    = slots[head_idx].told;
        head_done    = done[head_idx];
        last_entry   = slots[last_idx];
    end

    // Completion must not target the slot being allocated.
    assert_cmpl_not_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cmpl_en && (wr_idx == cmpl_idx)));
endmodule

// File: rtl/rollback_rob.sv
// Reorder buffer holding control state only, with in-order retirement
// that reports the previous tag, and a serial youngest-first rollback.
// Assumes completions and recovery boundaries name held slots.
module rollback_rob
    import rob_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [ID_W-1:0]   disp_id,
    input  logic              disp_has_dst,
    input  logic [AREG_W-1:0] disp_areg,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [TAG_W-1:0]  disp_told,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_idx,
    output logic              ret_valid,
    output logic [ID_W-1:0]   ret_id,
    output logic              ret_has_dst,
    output logic [TAG_W-1:0]  ret_told,
    output logic              undo_valid,
    output logic [ID_W-1:0]   undo_id,
    output logic              undo_has_dst,
    output logic [AREG_W-1:0] undo_areg,
    output logic [TAG_W-1:0]  undo_tag,
    output logic [TAG_W-1:0]  undo_told,
    output logic              rb_busy
);
    logic [PTR_W-1:0] head_ptr;
    logic [PTR_W-1:0] tail_ptr;
    logic             disp_fire;
    logic             head_done;
    logic [IDX_W-1:0] last_idx;
    rob_entry_t       new_entry;
    rob_entry_t       last_entry;

    // Pack the dispatched instruction and locate the youngest slot.
    always_comb begin
        new_entry = '{id: disp_id, has_dst: disp_has_dst, areg: disp_areg,
                      tag: disp_tag, told: disp_told};
        last_idx  = tail_ptr[IDX_W-1:0] - IDX_W'(1);
        disp_idx  = tail_ptr[IDX_W-1:0];
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_req   (disp_valid),
        .head_done  (head_done),
        .flush_req  (flush_valid),
        .flush_idx  (flush_idx),
        .head_ptr   (head_ptr),
        .tail_ptr   (tail_ptr),
        .disp_fire  (disp_fire),
        .ret_fire   (ret_valid),
        .undo_fire  (undo_valid),
        .rb_busy    (rb_busy),
        .disp_ready (disp_ready)
    );

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (disp_fire),
        .wr_idx       (tail_ptr[IDX_W-1:0]),
        .wr_entry     (new_entry),
        .cmpl_en      (cmpl_valid),
        .cmpl_idx     (cmpl_idx),
        .head_idx     (head_ptr[IDX_W-1:0]),
        .last_idx     (last_idx),
        .head_id      (ret_id),
        .head_has_dst (ret_has_dst),
        .head_told    (ret_told),
        .head_done    (head_done),
        .last_entry   (last_entry)
    );

    // Undo command fields come from the youngest held slot.
    always_comb begin
        undo_id      = last_entry.id;
        undo_has_dst = last_entry.has_dst;
        undo_areg    = last_entry.areg;
        undo_tag     = last_entry.tag;
        undo_told    = last_entry.told;
    end

    // Retiring and undoing never share a cycle.
    assert_ret_undo_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && undo_valid));

    // No dispatch is accepted during a walk.
    assert_no_dispatch_in_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |-> !disp_ready);

    // Undo only occurs inside a walk.
    assert_undo_in_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undo_valid |-> rb_busy);

    // Only a finished head retires.
    assert_retire_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> head_done);
endmodule

// File: tb/rollback_rob_bench.sv
`timescale 1ns/1ps
module rollback_rob_bench;
    import rob_pkg::*;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              disp_valid;
    logic [ID_W-1:0]   disp_id;
    logic              disp_has_dst;
    logic [AREG_W-1:0] disp_areg;
    logic [TAG_W-1:0]  disp_tag;
    logic [TAG_W-1:0]  disp_told;
    logic              disp_ready;
    logic [IDX_W-1:0]  disp_idx;
    logic              cmpl_valid;
    logic [IDX_W-1:0]  cmpl_idx;
    logic              flush_valid;
    logic [IDX_W-1:0]  flush_idx;
    logic              ret_valid;
    logic [ID_W-1:0]   ret_id;
    logic              ret_has_dst;
    logic [TAG_W-1:0]  ret_told;
    logic              undo_valid;
    logic [ID_W-1:0]   undo_id;
    logic              undo_has_dst;
    logic [AREG_W-1:0] undo_areg;
    logic [TAG_W-1:0]  undo_tag;
    logic [TAG_W-1:0]  undo_told;
    logic              rb_busy;

    rollback_rob #(.DEPTH(DEPTH)) u_rollback_rob (.*);

    typedef struct {
        int id; bit has; int areg; int tag; int told; int slot; bit done;
    } exp_t;

    exp_t mdl[$];
    int   tail_m = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_ret = 0;
    int   n_undo = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pops the model as retirements and undos appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ret_valid) begin
                if (mdl.size() == 0) begin
                    chk("R4", "retire from empty model", 1, 0);
                end else begin
                    chk("R4", "retire order id", ret_id, mdl[0].id);
                    chk("R4", "retired head was completed", mdl[0].done, 1);
                    chk("R5", "retire has_dst", ret_has_dst, mdl[0].has);
                    if (mdl[0].has) chk("R5", "retire told", ret_told, mdl[0].told);
                    void'(mdl.pop_front());
                    n_ret++;
                end
            end
            if (undo_valid) begin
                if (mdl.size() == 0) begin
                    chk("R6", "undo from empty model", 1, 0);
                end else begin
                    chk("R6", "undo id youngest first", undo_id, mdl[$].id);
                    chk("R6", "undo has_dst", undo_has_dst, mdl[$].has);
                    if (mdl[$].has) begin
                        chk("R6", "undo areg", undo_areg, mdl[$].areg);
                        chk("R6", "undo tag", undo_tag, mdl[$].tag);
                        chk("R6", "undo told", undo_told, mdl[$].told);
                    end
                    void'(mdl.pop_back());
                    tail_m--;
                    n_undo++;
                end
            end
        end
    end

    // Driver: one dispatch attempt; pushes the expected entry if accepted.
    task automatic dispatch(int id, bit has, bit exp_ok, string req);
        disp_valid   = 1'b1;
        disp_id      = ID_W'(id);
        disp_has_dst = has;
        disp_areg    = AREG_W'(id % 32);
        disp_tag     = TAG_W'(id + 40);
        disp_told    = TAG_W'(id + 3);
        #1;
        chk("R3", "disp_ready", disp_ready, exp_ok);
        if (exp_ok) begin
            chk(req, "disp_idx", disp_idx, tail_m % DEPTH);
            mdl.push_back('{id: id, has: has, areg: id % 32, tag: id + 40,
                            told: id + 3, slot: tail_m % DEPTH, done: 1'b0});
            tail_m++;
        end
        tick();
        disp_valid = 1'b0;
    endtask

    task automatic mark_done(int slot);
        foreach (mdl[i]) if (mdl[i].slot == slot) mdl[i].done = 1'b1;
    endtask

    task automatic complete(int slot);
        cmpl_valid = 1'b1;
        cmpl_idx   = IDX_W'(slot);
        mark_done(slot);
        tick();
        cmpl_valid = 1'b0;
    endtask

    // Recovery request plus walk measurement. Caller may preset a
    // concurrent dispatch or completion on the same cycle.
    task automatic flush_walk(int keep, int exp_k, bit disturb, string req);
        int u0;
        int cnt;
        u0 = n_undo;
        flush_valid = 1'b1;
        flush_idx   = IDX_W'(keep);
        tick();
        flush_valid = 1'b0;
        disp_valid  = 1'b0;
        cmpl_valid  = 1'b0;
        chk(req, "rb_busy after request", rb_busy, 1);
        cnt = 0;
        while (rb_busy && cnt < 40) begin
            if (disturb && cnt == 0) begin
                disp_valid  = 1'b1;
                disp_id     = 8'hEE;
                flush_valid = 1'b1;
                flush_idx   = IDX_W'(keep - 1);
                #1;
                chk("R8", "disp_ready during walk", disp_ready, 0);
                chk("R8", "ret_valid during walk", ret_valid, 0);
            end
            cnt++;
            tick();
            disp_valid  = 1'b0;
            flush_valid = 1'b0;
        end
        chk("R7", "busy cycles", cnt, exp_k + 1);
        chk(req, "undo count", n_undo - u0, exp_k);
    endtask

    initial begin
        #(20 * 200000);
        chk("WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; disp_valid = 1'b0; disp_id = '0; disp_has_dst = 1'b0;
        disp_areg = '0; disp_tag = '0; disp_told = '0; cmpl_valid = 1'b0;
        cmpl_idx = '0; flush_valid = 1'b0; flush_idx = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1", "disp_ready", disp_ready, 1);
        chk("R1", "disp_idx", disp_idx, 0);
        chk("R1", "ret_valid", ret_valid, 0);
        chk("R1", "undo_valid", undo_valid, 0);
        chk("R1", "rb_busy", rb_busy, 0);

        // R2: fill, slots 0..7; id 4 has no destination
        for (int i = 1; i <= DEPTH; i++) dispatch(i, i != 4, 1'b1, "R2");
        // R3: full, request dropped
        dispatch(99, 1'b1, 1'b0, "R3");

        // R4: younger completion does not retire
        complete(2);
        #1 chk("R4", "no retire with unfinished head", ret_valid, 0);
        complete(0);
        complete(1);
        repeat (3) tick();
        chk("R4", "retired count in order", n_ret, 3);
        chk("R3", "disp_ready after retire", disp_ready, 1);

        // R5: retire of the entry without destination (slot 3)
        complete(3);
        repeat (2) tick();
        chk("R5", "retired count", n_ret, 4);

        // R6/R8: completion of head in the request cycle, disturbances during walk
        cmpl_valid = 1'b1;
        cmpl_idx   = IDX_W'(4);
        mark_done(4);
        flush_walk(5, 2, 1'b1, "R6");
        repeat (2) tick();
        chk("R8", "head retires after walk", n_ret, 5);

        // R7: undone slot reused
        dispatch(20, 1'b1, 1'b1, "R7");
        chk("R7", "next slot after reuse", tail_m % DEPTH, 7);

        // R9: dispatch in the same cycle as the request
        disp_valid = 1'b1; disp_id = 8'd21; disp_has_dst = 1'b1;
        disp_areg = AREG_W'(21); disp_tag = TAG_W'(61); disp_told = TAG_W'(24);
        #1;
        chk("R9", "disp_idx", disp_idx, 7);
        mdl.push_back('{id: 21, has: 1'b1, areg: 21, tag: 61, told: 24,
                        slot: 7, done: 1'b0});
        tail_m++;
        flush_walk(5, 2, 1'b0, "R9");

        // R10: boundary is the youngest slot
        flush_walk(5, 0, 1'b0, "R10");

        // R6/R7: walk across the wrap point
        for (int i = 30; i <= 34; i++) dispatch(i, 1'b1, 1'b1, "R2");
        complete(5);
        repeat (2) tick();
        chk("R5", "retired count", n_ret, 6);
        flush_walk(7, 3, 1'b0, "R6");
        dispatch(40, 1'b1, 1'b1, "R7");
        chk("R7", "slot 0 reused", mdl[$].slot, 0);
        complete(6);
        complete(7);
        complete(0);
        repeat (3) tick();
        chk("R7", "all kept entries retired", n_ret, 9);
        chk("R7", "model drained", mdl.size(), 0);
        chk("R1", "no stray undo", undo_valid, 0);
        finish_run();
    end
endmodule